// File: doc/BRIEF.md
# Reset Cause Capture Register

This block records which source caused the most recent reset of a small microcontroller and presents the result as one 8-bit read-only register on a simple select/write bus. Each reset source delivers a one-cycle strobe: power-on, external pin, watchdog, illegal opcode, illegal address, USB and low-voltage. Flags from sources other than power-on collect in the register until software reads it. A read returns the current flags and clears them on the same clock edge.

For every internal reset, the block asserts an open-drain pull-down request on the external reset pin for a fixed stretch of cycles. When that request ends, a second timer waits a fixed number of cycles and then samples the pin level once. If the pin is still low at that sample, the pin flag is added to the register. A power-on event replaces the register contents with the power-on pattern alone.

Top module: `rst_cause_reg`

## Requirements
- R1: `rd_data_o` shows, from bit 7 down to bit 1: power-on, pin, watchdog, illegal opcode, illegal address, USB, low-voltage. Bit 0 always reads 0.
- R2: After `rst_n` has been released, `rd_data_o` reads 8'h80 and `pin_pull_o` is low.
- R3: A `pwr_evt_i` strobe in cycle k makes `rd_data_o` equal 8'h80 from cycle k+1, whatever else happens in cycle k.
- R4: A strobe from a source other than power-on sets its bit from the next cycle and leaves every bit already set unchanged.
- R5: A read (`bus_sel_i`=1, `bus_wr_i`=0) shows the flags held before it during that cycle and clears every flag at the following clock edge.
- R6: When a strobe arrives in the same cycle as a read, its bit stays set after the clear.
- R7: A write access (`bus_sel_i`=1, `bus_wr_i`=1) changes no flag.
- R8: An internal reset strobe (every source except the external pin) in cycle k drives `pin_pull_o` high for cycles k+1 to k+PULL_LEN. A new internal strobe while the pull is active restarts this stretch. An external-pin strobe does not pull the pin.
- R9: If cycle t is the last cycle with `pin_pull_o` high, `pin_lvl_i` is sampled in cycle t+SAMPLE_DLY. A low level at that sample sets the pin flag from cycle t+SAMPLE_DLY+1.
- R10: An internal strobe before the sample cancels the pending sample, and the delay counts again from the next release. Each release produces at most one sample.
- R11: An `extpin_evt_i` strobe sets the pin flag directly from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_evt_i | input | 1 | Power-on reset strobe |
| extpin_evt_i | input | 1 | External reset pin strobe |
| wdog_evt_i | input | 1 | Watchdog reset strobe |
| badop_evt_i | input | 1 | Illegal opcode reset strobe |
| badadr_evt_i | input | 1 | Illegal address reset strobe |
| usb_evt_i | input | 1 | USB reset strobe |
| lowv_evt_i | input | 1 | Low-voltage reset strobe |
| pin_lvl_i | input | 1 | Synchronised level of the external reset pin (1 = high) |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Access direction (1 = write, ignored) |
| rd_data_o | output | 8 | Register contents |
| pin_pull_o | output | 1 | Request to pull the external reset pin low |

## Verification
The bench builds the block with PULL_LEN=6 and the default SAMPLE_DLY=32. The short pull stretch lets many release-and-sample windows fit into a few thousand cycles. The full sample delay keeps the exact sample cycle under test. With this setting, strobes that land inside a pull stretch, inside a sample window, and on the sample cycle itself all occur in the directed sequences and in a long random run. Collisions of the pin sample with reads and with power-on also come within reach.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  // Flag record, packed MSB first so that {flags, 1'b0} is the visible register.
  typedef struct packed {
    logic pwr;
    logic pin;
    logic wdog;
    logic badop;
    logic badadr;
    logic usb;
    logic lowv;
  } rsr_flags_t;

  localparam int unsigned REG_W = 8;

  localparam rsr_flags_t FLAGS_NONE = '{pwr: 1'b0, pin: 1'b0, wdog: 1'b0, badop: 1'b0,
                                        badadr: 1'b0, usb: 1'b0, lowv: 1'b0};
  localparam rsr_flags_t FLAGS_PWR  = '{pwr: 1'b1, pin: 1'b0, wdog: 1'b0, badop: 1'b0,
                                        badadr: 1'b0, usb: 1'b0, lowv: 1'b0};

  function automatic logic [REG_W-1:0] rsr_to_reg(input rsr_flags_t f);
    return {f, 1'b0};
  endfunction

endpackage

// File: rtl/rsr_rst_sync.sv
module rsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rsr_pull_timer.sv
module rsr_pull_timer #(
  parameter int unsigned PULL_LEN   = 16,
  parameter int unsigned SAMPLE_DLY = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_evt,
  output logic pull_o,
  output logic smp_fire
);
  localparam int unsigned PW = $clog2(PULL_LEN + 1);
  localparam int unsigned SW = $clog2(SAMPLE_DLY + 1);
  localparam logic [PW-1:0] PULL_LOAD = PW'(PULL_LEN);
  localparam logic [SW-1:0] SMP_LOAD  = SW'(SAMPLE_DLY);

  logic [PW-1:0] pull_q, pull_d;
  logic [SW-1:0] smp_q, smp_d;
  logic          pull_en, smp_en;

  // Next-state logic for the pull stretch and the sample window.
  always_comb begin
    pull_d  = pull_q;
    pull_en = 1'b0;
    if (int_evt) begin
      pull_d  = PULL_LOAD;
      pull_en = 1'b1;
    end else if (pull_q != '0) begin
      pull_d  = pull_q - 1'b1;
      pull_en = 1'b1;
    end

    smp_d  = smp_q;
    smp_en = 1'b0;
    if (int_evt) begin
      smp_d  = '0;
      smp_en = 1'b1;
    end else if (pull_q == PW'(1)) begin
      smp_d  = SMP_LOAD;
      smp_en = 1'b1;
    end else if (smp_q != '0) begin
      smp_d  = smp_q - 1'b1;
      smp_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= '0;
      smp_q  <= '0;
    end else begin
      if (pull_en) pull_q <= pull_d;
      if (smp_en)  smp_q  <= smp_d;
    end
  end

  assign pull_o   = (pull_q != '0);
  assign smp_fire = !int_evt && (smp_q == SW'(1));
endmodule

// File: rtl/rsr_flag_bank.sv
module rsr_flag_bank
  import rsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_evt,
  input  rsr_flags_t set_vec,
  input  logic       clr,
  output rsr_flags_t flags_o
);
  rsr_flags_t flags_q, flags_d;
  logic       flags_en;

  always_comb begin
    flags_en = pwr_evt || clr || (set_vec != FLAGS_NONE);
    if (pwr_evt) flags_d = FLAGS_PWR;
    else         flags_d = (clr ? FLAGS_NONE : flags_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= FLAGS_PWR;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsr_pkg::*;
#(
  parameter int unsigned PULL_LEN   = 16,
  parameter int unsigned SAMPLE_DLY = 32,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_evt_i,
  input  logic             extpin_evt_i,
  input  logic             wdog_evt_i,
  input  logic             badop_evt_i,
  input  logic             badadr_evt_i,
  input  logic             usb_evt_i,
  input  logic             lowv_evt_i,
  input  logic             pin_lvl_i,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pin_pull_o
);
  logic       rst_n_s;
  logic       int_evt;
  logic       smp_fire;
  logic       rd_clr;
  rsr_flags_t set_vec;
  rsr_flags_t flags;

  rsr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Every source except the external pin is internal and pulls the pin.
  assign int_evt = pwr_evt_i | wdog_evt_i | badop_evt_i | badadr_evt_i | usb_evt_i | lowv_evt_i;
  assign rd_clr  = bus_sel_i & ~bus_wr_i;

  rsr_pull_timer #(.PULL_LEN(PULL_LEN), .SAMPLE_DLY(SAMPLE_DLY)) u_pull (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .int_evt  (int_evt),
    .pull_o   (pin_pull_o),
    .smp_fire (smp_fire)
  );

  always_comb begin
    set_vec        = FLAGS_NONE;
    set_vec.pin    = extpin_evt_i | (smp_fire & ~pin_lvl_i);
    set_vec.wdog   = wdog_evt_i;
    set_vec.badop  = badop_evt_i;
    set_vec.badadr = badadr_evt_i;
    set_vec.usb    = usb_evt_i;
    set_vec.lowv   = lowv_evt_i;
  end

  rsr_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pwr_evt (pwr_evt_i),
    .set_vec (set_vec),
    .clr     (rd_clr),
    .flags_o (flags)
  );

  assign rd_data_o = rsr_to_reg(flags);
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr,
  input logic       ext,
  input logic       wdog,
  input logic       badop,
  input logic       badadr,
  input logic       usb,
  input logic       lowv,
  input logic       sel,
  input logic       wr,
  input logic [7:0] rd_data,
  input logic       pull,
  input logic       fire
);
  logic int_any;
  logic quiet;
  assign int_any = pwr | wdog | badop | badadr | usb | lowv;
  assign quiet   = !int_any && !ext && !fire;

  assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == 1'b0);

  assert_pwr_wipes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> rd_data == 8'h80);

  assert_flags_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && !wr) && !pwr) |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && quiet) |=> rd_data == 8'h00);

  assert_event_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && wdog && !pwr) |=> rd_data[5]);

  assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && quiet) |=> $stable(rd_data));

  assert_pull_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_any |=> pull);

  assert_no_sample_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_any |-> !fire);
endmodule

bind rst_cause_reg rsr_checker u_rsr_checker (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .pwr     (pwr_evt_i),
  .ext     (extpin_evt_i),
  .wdog    (wdog_evt_i),
  .badop   (badop_evt_i),
  .badadr  (badadr_evt_i),
  .usb     (usb_evt_i),
  .lowv    (lowv_evt_i),
  .sel     (bus_sel_i),
  .wr      (bus_wr_i),
  .rd_data (rd_data_o),
  .pull    (pin_pull_o),
  .fire    (smp_fire)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
  localparam int PL = 6;
  localparam int SD = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 0, ext = 0, wdog = 0, badop = 0, badadr = 0, usb = 0, lowv = 0;
  logic       pin_lvl = 1'b1, sel = 1'b0, wr = 1'b0;
  logic [7:0] rd_data;
  logic       pull;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  int    last_int = -100000;
  logic [7:0] m_flags = 8'h80;
  string cur_req = "R2";
  bit    done = 0;

  always #4 clk = ~clk;

  rst_cause_reg #(.PULL_LEN(PL), .SAMPLE_DLY(SD)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_evt_i(pwr), .extpin_evt_i(ext), .wdog_evt_i(wdog),
    .badop_evt_i(badop), .badadr_evt_i(badadr), .usb_evt_i(usb), .lowv_evt_i(lowv),
    .pin_lvl_i(pin_lvl), .bus_sel_i(sel), .bus_wr_i(wr), .rd_data_o(rd_data),
    .pin_pull_o(pull)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %02h expected %02h", req, cyc, act, exp);
    end
  endtask

  // ev: [6] power-on [5] ext pin [4] watchdog [3] bad opcode [2] bad address [1] usb [0] low-voltage
  task automatic step(input logic [6:0] ev, input logic s, input logic w, input logic p);
    bit   exp_pull;
    bit   int_now;
    bit   fire;
    logic [7:0] base;
    @(negedge clk);
    exp_pull = (cyc - last_int >= 1) && (cyc - last_int <= PL);
    check8({cur_req, " rd_data"}, rd_data, m_flags);
    check8({cur_req, " pull"}, {7'd0, pull}, {7'd0, exp_pull});
    {pwr, ext, wdog, badop, badadr, usb, lowv} = ev;
    sel = s; wr = w; pin_lvl = p;
    int_now = ev[6] | ev[4] | ev[3] | ev[2] | ev[1] | ev[0];
    fire = !int_now && (cyc == last_int + PL + SD);
    if (ev[6]) m_flags = 8'h80;
    else begin
      base = (s && !w) ? 8'h00 : m_flags;
      base = base | {ev, 1'b0};
      if (fire && !p) base[6] = 1'b1;
      m_flags = base;
    end
    if (int_now) last_int = cyc;
    cyc++;
  endtask

  task automatic idle(input int n, input logic p);
    for (int i = 0; i < n; i++) step(7'b0, 1'b0, 1'b0, p);
  endtask

  task automatic rd();
    step(7'b0, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R2 reset value and idle pin request
    @(negedge clk);
    check8("R2 reset value", rd_data, 8'h80);
    check8("R2 pull idle", {7'd0, pull}, 8'h00);
    cur_req = "R2"; idle(2, 1'b1);

    cur_req = "R5 read clears"; rd(); idle(2, 1'b1);
    cur_req = "R4 accumulate wdog/usb/lowv";
    step(7'b0010000, 0, 0, 1); idle(3, 1); step(7'b0000010, 0, 0, 1);
    step(7'b0000001, 0, 0, 1); idle(2, 1);
    cur_req = "R1 layout"; idle(1, 1);
    cur_req = "R9 pin high at sample"; idle(PL + SD + 4, 1'b1);
    cur_req = "R5 read clears"; rd(); idle(1, 1);
    cur_req = "R9 pin low at sample"; step(7'b0001000, 0, 0, 1); idle(PL + SD + 3, 1'b0);
    cur_req = "R5"; rd(); idle(1, 1);
    cur_req = "R9 pin low only on sample cycle";
    step(7'b0000100, 0, 0, 1); idle(PL + SD - 1, 1'b1); idle(1, 1'b0); idle(3, 1'b1);
    rd();
    cur_req = "R9 pin low only one cycle late";
    step(7'b0000100, 0, 0, 1); idle(PL + SD, 1'b1); idle(1, 1'b0); idle(3, 1'b1);
    cur_req = "R8 restart during pull"; step(7'b0010000, 0, 0, 1); idle(3, 1);
    step(7'b0000001, 0, 0, 1); idle(PL + 2, 1);
    cur_req = "R10 event inside sample window"; idle(10, 0); step(7'b0000010, 0, 0, 0);
    idle(PL + SD + 4, 0);
    cur_req = "R6 event beats clear"; step(7'b0010000, 1, 0, 1); idle(2, 1);
    step(7'b0100000, 1, 0, 1); idle(2, 1);
    cur_req = "R7 write ignored"; step(7'b0, 1, 1, 1); step(7'b0, 1, 1, 1); idle(2, 1);
    cur_req = "R11 ext pin, no pull"; rd(); step(7'b0100000, 0, 0, 1); idle(3, 1);
    cur_req = "R3 power-on wipes"; step(7'b1111111, 1, 0, 0); idle(2, 1);
    step(7'b1000000, 0, 1, 1); idle(PL + SD + 3, 0);
    cur_req = "R1-R11 random";
    for (int i = 0; i < 6000; i++) begin
      logic [6:0] ev;
      ev = '0;
      for (int b = 0; b < 7; b++) if ($urandom_range(0, 299) == 0) ev[b] = 1'b1;
      step(ev, $urandom_range(0, 19) == 0, $urandom_range(0, 1) == 0, $urandom_range(0, 2) != 0);
    end
    idle(2, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule